// File: doc/BRIEF.md
# Two-Line Maskable Interrupt Router

This block collects up to 32 interrupt request lines from peripherals and drives two processor interrupt inputs: a normal line and a fast line. A per-source enable register decides whether each request may reach the processor at all. A per-source steering register then sends each enabled request to exactly one of the two lines. Software reads the combined results through three read-only views. One shows the live requests. One shows the enabled requests steered to the normal line. One shows the enabled requests steered to the fast line.

The block does no priority encoding and produces no vector. Software reads the relevant view and picks a source itself. The request inputs are level signals that the sources hold until they are serviced, so the views and both output lines follow them with no storage. Register writes take effect at the next rising clock edge. Register reads return the selected word combinationally from the current offset.

Top module: `irq_fiq_router`

## Requirements
- R1: After reset the enable, steering and control registers read zero, and both output lines stay low even when every request input is high.
- R2: The enable register (offset 1) and the steering register (offset 2) are full-width read/write registers. A write at a clock edge is visible on the read port from that edge on.
- R3: The control register (offset 3) stores only bit 0. Bits above bit 0 are discarded on write and read as zero.
- R4: The live-request view (offset 0) always reads the current request input vector.
- R5: The normal-line view (offset 4) reads request AND enable AND NOT steering for every bit, so a steering bit of 0 selects the normal line.
- R6: The fast-line view (offset 5) reads request AND enable AND steering for every bit, so a steering bit of 1 selects the fast line.
- R7: The normal output is high exactly when the normal-line view is nonzero. The fast output is high exactly when the fast-line view is nonzero.
- R8: Writes to offsets 0, 4 and 5 change no register and no output.
- R9: Offsets 6 and 7 read zero, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Level request from each source |
| reg_addr | input | ADDR_W | Word offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data for the word at reg_addr |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The hard case to reach is one source whose enable and steering bits disagree with those of its neighbours. A fault in one bit lane, such as a swapped polarity or a missing AND term, stays hidden while the other sources hold either output high. The bench therefore walks a single enabled source through all 32 lanes, once on each line, with every other source disabled. It then runs pseudo-random mixes of requests, enables and steering, and finally writes pseudo-random data to every read-only and unmapped offset before it reads the full register file back.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  localparam int unsigned OFS_RAW   = 0;
  localparam int unsigned OFS_MASK  = 1;
  localparam int unsigned OFS_ROUTE = 2;
  localparam int unsigned OFS_CTRL  = 3;
  localparam int unsigned OFS_IRQV  = 4;
  localparam int unsigned OFS_FIQV  = 5;

  typedef enum logic [2:0] {
    RS_RAW,
    RS_MASK,
    RS_ROUTE,
    RS_CTRL,
    RS_IRQV,
    RS_FIQV,
    RS_NONE
  } regsel_e;

  // Offset decode. Callers zero-extend their address to 16 bits.
  function automatic regsel_e sel_of(input logic [15:0] ofs);
    case (ofs)
      16'(OFS_RAW):   return RS_RAW;
      16'(OFS_MASK):  return RS_MASK;
      16'(OFS_ROUTE): return RS_ROUTE;
      16'(OFS_CTRL):  return RS_CTRL;
      16'(OFS_IRQV):  return RS_IRQV;
      16'(OFS_FIQV):  return RS_FIQV;
      default:        return RS_NONE;
    endcase
  endfunction

  // A register that software may change.
  function automatic logic sel_writable(input regsel_e s);
    return (s == RS_MASK) || (s == RS_ROUTE) || (s == RS_CTRL);
  endfunction

  // One lane of the router: a request passes when it is enabled and
  // steered to the requested line (fast = 1 selects the fast line).
  function automatic logic lane_pass(input logic req, input logic en,
                                     input logic steer, input logic fast);
    return req & en & (steer == fast);
  endfunction

endpackage

// File: rtl/irqr_regs.sv
module irqr_regs
  import irqr_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mask,
  input  logic            wr_route,
  input  logic            wr_ctrl,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] route_q,
  output logic            ctrl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
      ctrl_q  <= 1'b0;
    end else begin
      if (wr_mask)  mask_q  <= wdata;
      if (wr_route) route_q <= wdata;
      if (wr_ctrl)  ctrl_q  <= wdata[0];
    end
  end

endmodule

// File: rtl/irqr_route.sv
module irqr_route
  import irqr_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] route,
  output logic [NSRC-1:0] irq_vec,
  output logic [NSRC-1:0] fiq_vec,
  output logic            irq_any,
  output logic            fiq_any
);

  for (genvar i = 0; i < NSRC; i++) begin : g_lane
    assign irq_vec[i] = lane_pass(src[i], mask[i], route[i], 1'b0);
    assign fiq_vec[i] = lane_pass(src[i], mask[i], route[i], 1'b1);
  end

  assign irq_any = |irq_vec;
  assign fiq_any = |fiq_vec;

endmodule

// File: rtl/irqr_rdmux.sv
module irqr_rdmux
  import irqr_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  regsel_e         sel,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] route,
  input  logic            ctrl,
  input  logic [NSRC-1:0] irq_vec,
  input  logic [NSRC-1:0] fiq_vec,
  output logic [NSRC-1:0] rdata
);

  localparam int unsigned PAD_W = NSRC - 1;

  always_comb begin
    case (sel)
      RS_RAW:   rdata = raw;
      RS_MASK:  rdata = mask;
      RS_ROUTE: rdata = route;
      RS_CTRL:  rdata = {{PAD_W{1'b0}}, ctrl};
      RS_IRQV:  rdata = irq_vec;
      RS_FIQV:  rdata = fiq_vec;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_fiq_router.sv
module irq_fiq_router
  import irqr_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_o,
  output logic              fiq_o
);

  // Named internal events, brought out for the checker.
  regsel_e         acc_sel;
  logic            wr_mask, wr_route, wr_ctrl, wr_dropped;
  logic [NSRC-1:0] mask_q, route_q;
  logic            ctrl_q;
  logic [NSRC-1:0] irq_vec, fiq_vec;

  assign acc_sel    = sel_of(16'(reg_addr));
  assign wr_mask    = reg_wr && (acc_sel == RS_MASK);
  assign wr_route   = reg_wr && (acc_sel == RS_ROUTE);
  assign wr_ctrl    = reg_wr && (acc_sel == RS_CTRL);
  assign wr_dropped = reg_wr && !sel_writable(acc_sel);

  irqr_regs #(.NSRC(NSRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_mask),
    .wr_route(wr_route),
    .wr_ctrl (wr_ctrl),
    .wdata   (reg_wdata),
    .mask_q  (mask_q),
    .route_q (route_q),
    .ctrl_q  (ctrl_q)
  );

  irqr_route #(.NSRC(NSRC)) u_route (
    .src    (src_req),
    .mask   (mask_q),
    .route  (route_q),
    .irq_vec(irq_vec),
    .fiq_vec(fiq_vec),
    .irq_any(irq_o),
    .fiq_any(fiq_o)
  );

  irqr_rdmux #(.NSRC(NSRC)) u_rdmux (
    .sel    (acc_sel),
    .raw    (src_req),
    .mask   (mask_q),
    .route  (route_q),
    .ctrl   (ctrl_q),
    .irq_vec(irq_vec),
    .fiq_vec(fiq_vec),
    .rdata  (reg_rdata)
  );

endmodule

// File: rtl/irqr_checker.sv
module irqr_checker
  import irqr_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input regsel_e         acc_sel,
  input logic            wr_mask,
  input logic            wr_dropped,
  input logic [NSRC-1:0] wdata,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] route_q,
  input logic            ctrl_q,
  input logic [NSRC-1:0] irq_vec,
  input logic [NSRC-1:0] fiq_vec,
  input logic [NSRC-1:0] rdata,
  input logic            irq_o,
  input logic            fiq_o
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0 && route_q == '0 && !ctrl_q));

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(wdata));

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

  assert_ctrl_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sel == RS_CTRL |-> rdata[NSRC-1:1] == '0);

  assert_raw_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sel == RS_RAW |-> rdata == src_req);

  assert_lines_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & fiq_vec) == '0);

  assert_fiq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_vec & ~(src_req & mask_q & route_q)) == '0);

  assert_irq_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (src_req & mask_q & ~route_q) != '0);

  assert_fiq_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (src_req & mask_q & route_q) != '0);

  assert_dropped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |=> ($stable(mask_q) && $stable(route_q) && $stable(ctrl_q)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sel == RS_NONE |-> rdata == '0);

endmodule

bind irq_fiq_router irqr_checker #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_sel   (acc_sel),
  .wr_mask   (wr_mask),
  .wr_dropped(wr_dropped),
  .wdata     (reg_wdata),
  .src_req   (src_req),
  .mask_q    (mask_q),
  .route_q   (route_q),
  .ctrl_q    (ctrl_q),
  .irq_vec   (irq_vec),
  .fiq_vec   (fiq_vec),
  .rdata     (reg_rdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o)
);

// File: tb/irq_fiq_router_tb.sv
module irq_fiq_router_tb;

  localparam int NSRC = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_req = '0;
  logic [2:0]      reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [NSRC-1:0] reg_wdata = '0;
  logic [NSRC-1:0] reg_rdata;
  logic            irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_mask = '0, m_route = '0, m_ctrl = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  irq_fiq_router #(.NSRC(NSRC), .ADDR_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Per-bit model: steering 0 -> normal line, 1 -> fast line.
  task automatic expect_views(output logic [31:0] ei, output logic [31:0] ef);
    ei = '0; ef = '0;
    for (int i = 0; i < NSRC; i++)
      if (src_req[i] && m_mask[i]) begin
        if (m_route[i]) ef[i] = 1'b1; else ei[i] = 1'b1;
      end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d, ei, ef;
    expect_views(ei, ef);
    rd(3'd0, d); chk({tag, " R4 raw"}, d, src_req);
    rd(3'd1, d); chk({tag, " R2 mask"}, d, m_mask);
    rd(3'd2, d); chk({tag, " R2 route"}, d, m_route);
    rd(3'd3, d); chk({tag, " R3 ctrl"}, d, m_ctrl);
    rd(3'd4, d); chk({tag, " R5 irqview"}, d, ei);
    rd(3'd5, d); chk({tag, " R6 fiqview"}, d, ef);
    rd(3'd6, d); chk({tag, " R9 unmapped6"}, d, 32'h0);
    rd(3'd7, d); chk({tag, " R9 unmapped7"}, d, 32'h0);
    chk({tag, " R7 irq_o"}, {31'h0, irq_o}, {31'h0, ei != 0});
    chk({tag, " R7 fiq_o"}, {31'h0, fiq_o}, {31'h0, ef != 0});
  endtask

  initial begin : watchdog
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    // R1: reset state, all requests high.
    src_req = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 reset");

    // R3: control keeps bit 0 only.
    wr(3'd3, 32'hFFFF_FFFF); m_ctrl = 32'h1; check_all("R3 ctrl all-ones");
    wr(3'd3, 32'hFFFF_FFFE); m_ctrl = 32'h0; check_all("R3 ctrl upper only");

    // R5/R6/R7: single enabled source in each lane, on each line.
    for (int b = 0; b < NSRC; b++) begin
      src_req = 32'h1 << b;
      wr(3'd1, 32'h1 << b); m_mask = 32'h1 << b;
      wr(3'd2, 32'h0); m_route = 32'h0;
      check_all("R5 lane normal");
      wr(3'd2, 32'h1 << b); m_route = 32'h1 << b;
      check_all("R6 lane fast");
      src_req = ~(32'h1 << b);
      check_all("R7 lane request off");
    end

    // R2/R4-R7: pseudo-random mixes.
    for (int k = 0; k < 150; k++) begin
      seed = nxt(seed); wr(3'd1, seed); m_mask = seed;
      seed = nxt(seed); wr(3'd2, seed); m_route = seed;
      seed = nxt(seed); src_req = seed;
      check_all("R2 mix");
    end

    // R8/R9: writes to read-only and unmapped offsets are dropped.
    for (int k = 0; k < 40; k++) begin
      seed = nxt(seed);
      wr(3'd0, seed); wr(3'd4, ~seed); wr(3'd5, seed ^ 32'hA5A5_A5A5);
      check_all("R8 ro write");
      seed = nxt(seed);
      wr(3'd6, seed); wr(3'd7, ~seed);
      check_all("R9 unmapped write");
    end

    // R1: reset again clears everything.
    @(negedge clk); rst_n = 1'b0; src_req = '1;
    m_mask = '0; m_route = '0; m_ctrl = '0;
    #1 rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(3'd1, d); chk("R1 mask after reset", d, 32'h0);
    check_all("R1 second reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule